// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Controller

This block sits on the host side of a chain of serial converters that share one conversion-start line and one serial clock, with each converter's data output feeding the data input of its neighbour. Only the converter nearest the host is wired back to the controller. On a start request the controller raises the conversion-start line while keeping the serial clock high, which puts every converter into the chained mode that signals completion on the data line. It then watches that line. A low-to-high transition tells it that every converter in the chain has finished.

When it sees that transition, the controller runs the serial clock for exactly one more period than the total number of data bits in the chain. It captures the returning stream and splits it into one 16-bit word per converter. It then drops the conversion-start line and publishes all words at once with a one-cycle strobe. If the completion transition never arrives, a timeout ends the conversion and raises an error flag instead. The chain length, the clock divider and the timeout are parameters.

Top module: `chain_rd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cnv_o` is low, `sck_o` is high, `done_o` and `timeout_o` are low, and `data_o` is all zeros.
- R2: A `start_i` pulse seen while idle raises `cnv_o` in the next cycle, with `sck_o` high at that moment. `sck_o` stays high until readback begins.
- R3: Readback starts only on a low-to-high transition of `sdo_i` while the conversion is pending. A line that is already high when the conversion starts does not start readback.
- R4: One readback produces exactly 16×NUM_DEV+1 falling edges on `sck_o`. Consecutive falling edges are 2×SCK_HALF clock cycles apart, and `cnv_o` stays high throughout.
- R5: The bit present on `sdo_i` just before each falling edge from the second one onward is captured, most significant bit first. The first 16 bits belong to the nearest converter. `data_o[16*i+15:16*i]` holds the word of the converter i positions up the chain (i=0 is the nearest).
- R6: When the readback ends, `cnv_o` falls and `done_o` is high for exactly one cycle, the same cycle in which `cnv_o` is first low. `data_o` then holds the new words unchanged until the next `done_o`.
- R7: If no transition arrives, `cnv_o` stays high for exactly TIMEOUT_CYC cycles and then falls. `timeout_o` then goes high, no `done_o` is issued, and `data_o` keeps its old value. `timeout_o` stays high until the next accepted start, which clears it.
- R8: `start_i` is ignored while a conversion or readback is in progress. After the readback, `cnv_o` stays low until a new start request.
- R9: Whenever `cnv_o` is low, `sck_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request for a new conversion and readback |
| sdo_i | input | 1 | Serial data and completion flag from the nearest converter |
| cnv_o | output | 1 | Conversion start, held high until readback ends |
| sck_o | output | 1 | Serial clock to all converters, idles high |
| data_o | output | 16×NUM_DEV | Received words, nearest converter in the low 16 bits |
| done_o | output | 1 | One-cycle strobe marking new words on data_o |
| timeout_o | output | 1 | Completion flag missing within TIMEOUT_CYC cycles |

## Verification
The hardest case to reach from the ports is a data line that is already high when the conversion starts. A correct converter chain never does this, so the bench ORs a forcing term onto the chained line. The term holds the line high through the first part of a slow conversion and is then released. The bench checks that no clock edge appears until the genuine completion transition follows. The timeout path needs a chain slower than the timeout limit. For that case the bench counts the cycles that `cnv_o` is high and confirms that the old words and the absent strobe survive.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } rd_state_e;

endpackage

// File: rtl/chain_rd_tick.sv
// Half-period tick for the serial clock: fires once every HALF cycles while run_i is high.
module chain_rd_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/chain_rd_shreg.sv
// Serial-in stream register; new bits enter at the LSB so the first bit ends at the top.
module chain_rd_shreg #(
    parameter int BITS = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_i,
    input  logic            bit_i,
    output logic [BITS-1:0] bits_o
);
    logic [BITS-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_i) sh_d = {sh_q[BITS-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign bits_o = sh_q;
endmodule

// File: rtl/chain_rd_ctrl.sv
module chain_rd_ctrl
    import chain_rd_pkg::*;
#(
    parameter int NUM_DEV     = 3,
    parameter int WORD_W      = 16,
    parameter int SCK_HALF    = 2,
    parameter int TIMEOUT_CYC = 2000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        sdo_i,
    output logic                        cnv_o,
    output logic                        sck_o,
    output logic [NUM_DEV*WORD_W-1:0]   data_o,
    output logic                        done_o,
    output logic                        timeout_o
);
    localparam int TOT    = NUM_DEV * WORD_W;
    localparam int FALLS  = TOT + 1;
    localparam int FALL_W = $clog2(FALLS + 1);
    localparam int TMO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam logic [FALL_W-1:0] FALL_LAST = FALL_W'(FALLS);
    localparam logic [TMO_W-1:0]  TMO_LAST  = TMO_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        rd_state_e         st;
        logic              cnv;
        logic              sck;
        logic              sdo_prev;
        logic              done;
        logic              tmo;
        logic [FALL_W-1:0] falls;
        logic [TMO_W-1:0]  tcnt;
        logic [TOT-1:0]    data;
    } regs_t;

    localparam regs_t RST = '{
        st: ST_IDLE, cnv: 1'b0, sck: 1'b1, sdo_prev: 1'b0, done: 1'b0,
        tmo: 1'b0, falls: '0, tcnt: '0, data: '0
    };

    regs_t r_d, r_q;
    logic  tick;
    logic  shift;
    logic  run;
    logic [TOT-1:0] stream;
    logic [TOT-1:0] words_w;

    chain_rd_tick #(.HALF(SCK_HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    chain_rd_shreg #(.BITS(TOT)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift),
        .bit_i   (sdo_i),
        .bits_o  (stream)
    );

    // First received word sits at the top of the stream; it belongs in the low slot.
    for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_unpack
        assign words_w[gi*WORD_W +: WORD_W] = stream[TOT-1-gi*WORD_W -: WORD_W];
    end

    assign run = (r_q.st == ST_READ);

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.sdo_prev = sdo_i;
        shift        = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sck = 1'b1;
                r_d.cnv = 1'b0;
                if (start_i) begin
                    r_d.st   = ST_CONV;
                    r_d.cnv  = 1'b1;
                    r_d.tcnt = '0;
                    r_d.tmo  = 1'b0;
                end
            end
            ST_CONV: begin
                if (sdo_i && !r_q.sdo_prev) begin
                    r_d.st    = ST_READ;
                    r_d.falls = '0;
                end else if (r_q.tcnt == TMO_LAST) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnv = 1'b0;
                    r_d.tmo = 1'b1;
                end else begin
                    r_d.tcnt = r_q.tcnt + 1'b1;
                end
            end
            ST_READ: begin
                if (tick) begin
                    if (r_q.sck) begin
                        r_d.sck   = 1'b0;
                        r_d.falls = r_q.falls + 1'b1;
                        shift     = (r_q.falls != '0);
                    end else begin
                        r_d.sck = 1'b1;
                        if (r_q.falls == FALL_LAST) begin
                            r_d.st   = ST_IDLE;
                            r_d.cnv  = 1'b0;
                            r_d.done = 1'b1;
                            r_d.data = words_w;
                        end
                    end
                end
            end
            default: r_d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign cnv_o     = r_q.cnv;
    assign sck_o     = r_q.sck;
    assign data_o    = r_q.data;
    assign done_o    = r_q.done;
    assign timeout_o = r_q.tmo;
endmodule

// File: rtl/chain_rd_chk.sv
module chain_rd_chk #(
    parameter int NUM_DEV = 3,
    parameter int WORD_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cnv_o,
    input logic                      sck_o,
    input logic [NUM_DEV*WORD_W-1:0] data_o,
    input logic                      done_o,
    input logic                      timeout_o
);
    localparam int FALLS = NUM_DEV * WORD_W + 1;

    logic sck_prev;
    int   fall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b1;
            fall_cnt <= 0;
        end else begin
            sck_prev <= sck_o;
            if (!cnv_o)                 fall_cnt <= 0;
            else if (sck_prev && !sck_o) fall_cnt <= fall_cnt + 1;
        end
    end

    // R2
    cnv_rise_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> sck_o);

    // R9
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_o |-> sck_o);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    done_with_cnv_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cnv_o && $past(cnv_o)));

    // R4
    fall_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fall_cnt == FALLS));

    // R7
    timeout_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (!done_o && !cnv_o));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(data_o));
endmodule

bind chain_rd_ctrl chain_rd_chk #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_o     (cnv_o),
    .sck_o     (sck_o),
    .data_o    (data_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
);

// File: tb/test_chain_rd_ctrl.sv
// Behavioural converter in chained mode: completion flag ANDed down the chain, 16-bit shift on SCK falls.
module chain_dev_model (
    input  logic        clk,
    input  logic        cnv,
    input  logic        sck,
    input  logic        sdi,
    input  logic [15:0] sample,
    input  int          conv_cyc,
    output logic        sdo
);
    int          cnt = 0;
    logic        started = 1'b0;
    logic [15:0] sh = '0;
    logic        ready;

    always @(posedge clk) begin
        if (!cnv)              cnt <= 0;
        else if (cnt < 100000) cnt <= cnt + 1;
    end

    assign ready = cnv && (cnt >= conv_cyc);

    always @(posedge cnv or negedge sck) begin
        if (sck) begin
            sh      <= sample;
            started <= 1'b0;
        end else if (cnv && ready) begin
            if (!started) started <= 1'b1;
            else          sh <= {sh[14:0], sdi};
        end
    end

    assign sdo = started ? sh[15] : (ready & sdi);
endmodule

module test_chain_rd_ctrl;
    localparam int NUM_DEV  = 3;
    localparam int WORD_W   = 16;
    localparam int SCK_HALF = 2;
    localparam int TMO      = 600;
    localparam int FALLS    = NUM_DEV * WORD_W + 1;
    localparam time TCLK    = 4ns;

    // {conversion base cycles, far word, middle word, near word}
    localparam logic [63:0] VECS [6] = '{
        64'h000C_0000_0000_0000,
        64'h0010_FFFF_FFFF_FFFF,
        64'h0014_AAAA_5555_AAAA,
        64'h0020_8001_1234_F00D,
        64'h0040_7FFE_C3A5_0001,
        64'h0002_DEAD_BEEF_CAFE
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic force_hi = 1'b0;
    logic sdo_i, cnv_o, sck_o, done_o, timeout_o;
    logic [NUM_DEV*WORD_W-1:0] data_o;
    logic [NUM_DEV:0] link;
    logic [15:0] samp [NUM_DEV];
    int conv [NUM_DEV];

    int n_tests = 0, n_fail = 0;
    int falls_seen = 0, dones_seen = 0, hi_cycles = 0, bad_period = 0;
    time last_fall = 0, cnv_rise = 0;

    always #(TCLK/2) clk = ~clk;

    chain_rd_ctrl #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .SCK_HALF(SCK_HALF),
                    .TIMEOUT_CYC(TMO)) i_chain_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdo_i(sdo_i),
        .cnv_o(cnv_o), .sck_o(sck_o), .data_o(data_o), .done_o(done_o),
        .timeout_o(timeout_o)
    );

    assign link[NUM_DEV] = cnv_o;
    for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_dev
        chain_dev_model u_dev (
            .clk(clk), .cnv(cnv_o), .sck(sck_o), .sdi(link[gi+1]),
            .sample(samp[gi]), .conv_cyc(conv[gi]), .sdo(link[gi])
        );
    end
    assign sdo_i = force_hi | link[0];

    always @(posedge cnv_o) cnv_rise = $time;
    always @(negedge sck_o) begin
        falls_seen++;
        if (last_fall > cnv_rise && ($time - last_fall) != 2*SCK_HALF*TCLK) bad_period++;
        last_fall = $time;
    end
    always @(negedge clk) begin
        if (done_o) dones_seen++;
        if (cnv_o)  hi_cycles++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_end();
        int k = 0;
        while (!done_o && !timeout_o && k < 20000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic load(input logic [63:0] v);
        for (int i = 0; i < NUM_DEV; i++) begin
            samp[i] = v[16*i +: 16];
            conv[i] = int'(v[63:48]) + 5*i;
        end
    endtask

    task automatic check_words(input logic [63:0] v, input string req);
        for (int i = 0; i < NUM_DEV; i++)
            chk(data_o[16*i +: 16] == v[16*i +: 16], req, 64'(data_o[16*i +: 16]), 64'(v[16*i +: 16]));
    endtask

    task automatic run_vec(input logic [63:0] v);
        int f0, d0;
        load(v);
        f0 = falls_seen;
        d0 = dones_seen;
        pulse_start();
        chk(cnv_o && sck_o, "R2 cnv high with sck high", {62'd0, cnv_o, sck_o}, 64'd3);
        chk(!timeout_o, "R7 cleared by start", 64'(timeout_o), 64'd0);
        pulse_start();  // R8: ignored while busy
        wait_end();
        chk(done_o && !cnv_o, "R6 done with cnv low", {62'd0, done_o, cnv_o}, 64'd2);
        check_words(v, "R5 word order");
        @(negedge clk);
        chk(falls_seen - f0 == FALLS, "R4 fall count", 64'(falls_seen - f0), 64'(FALLS));
        chk(dones_seen - d0 == 1, "R6 single done", 64'(dones_seen - d0), 64'd1);
        chk(bad_period == 0, "R4 sck period", 64'(bad_period), 64'd0);
        repeat (12) @(negedge clk);
        chk(!cnv_o && sck_o, "R8 stays idle, R9 sck high", {62'd0, cnv_o, sck_o}, 64'd1);
        check_words(v, "R6 data held");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int f0, d0, h0;
        logic [NUM_DEV*WORD_W-1:0] held;
        load(64'h0010_0000_0000_0000);
        repeat (3) @(negedge clk);
        chk(!cnv_o && sck_o && !done_o && !timeout_o && data_o == '0, "R1 in reset",
            {59'd0, cnv_o, sck_o, done_o, timeout_o, |data_o}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cnv_o && sck_o && !done_o && !timeout_o && data_o == '0, "R1 after reset",
            {59'd0, cnv_o, sck_o, done_o, timeout_o, |data_o}, 64'h8);

        foreach (VECS[j]) run_vec(VECS[j]);

        // R7: chain slower than the timeout
        held = data_o;
        load(64'd900 << 48 | 64'h1111_2222_3333);
        f0 = falls_seen; d0 = dones_seen; h0 = hi_cycles;
        pulse_start();
        wait_end();
        chk(timeout_o && !cnv_o, "R7 timeout flag", {62'd0, timeout_o, cnv_o}, 64'd2);
        @(negedge clk);
        chk(hi_cycles - h0 == TMO, "R7 cnv high cycles", 64'(hi_cycles - h0), 64'(TMO));
        chk(falls_seen == f0 && dones_seen == d0, "R7 no clocks no done",
            64'(falls_seen - f0 + dones_seen - d0), 64'd0);
        chk(data_o == held && timeout_o, "R7 data kept, flag held", 64'(data_o == held), 64'd1);

        // R3: line already high at start must not trigger readback
        load(64'h012C_0F0F_F0F0_3C3C);
        f0 = falls_seen;
        force_hi = 1'b1;
        pulse_start();
        repeat (100) @(negedge clk);
        chk(falls_seen == f0 && cnv_o && sck_o, "R3 level does not trigger",
            64'(falls_seen - f0), 64'd0);
        force_hi = 1'b0;
        wait_end();
        chk(done_o, "R3 real edge triggers", 64'(done_o), 64'd1);
        check_words(64'h012C_0F0F_F0F0_3C3C, "R3 R5 words after forced line");
        @(negedge clk);
        chk(falls_seen - f0 == FALLS, "R4 fall count after forced line",
            64'(falls_seen - f0), 64'(FALLS));

        // R8: start during the serial phase
        load(64'h0008_1357_2468_9ABC);
        d0 = dones_seen;
        pulse_start();
        @(negedge sck_o);
        pulse_start();
        wait_end();
        repeat (20) @(negedge clk);
        chk(dones_seen - d0 == 1 && !cnv_o, "R8 start ignored in readback",
            64'(dones_seen - d0), 64'd1);
        check_words(64'h0008_1357_2468_9ABC, "R5 words after ignored start");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule